// File: doc/BRIEF.md
# Thermostat Setpoint Comparator with Resolution Masking

This block keeps two programmable temperature limits, an upper trip point and a lower release point. Each incoming temperature sample is compared against both limits, and a thermostat output is driven with hysteresis. Setpoints and samples share one number format: a 12-bit signed value in units of 1/16 °C. A setpoint is stored left-justified in a 16-bit word, with its four bottom bits held at zero. The comparison uses only the top 9, 10, 11 or 12 bits of each value, as chosen by a 2-bit resolution field. The bits below the chosen resolution are cleared on the sample and on both limits alike, so values that differ only in those bits compare equal.

Software reaches the limits through a byte-wide register port addressed by a pointer. Pointer 03h selects the trip point and 02h selects the release point. Each limit moves as two bytes, high byte first. A write takes effect only when its second byte arrives. After reset the trip point is +80 °C and the release point is +75 °C. When no thermostat function is wanted, the two words serve as plain scratch storage.

The block also emits a conversion-period tick. Its period doubles for each added bit of resolution. A new resolution setting is adopted at the next sample strobe, and that strobe also restarts the period counter.

Top module: `thermo_setpoint_unit`

## Requirements
- R1: After reset, reading pointer 03h returns 50h then 00h (trip point 5000h), and reading pointer 02h returns 4Bh then 00h (release point 4B00h). The first read at a pointer returns the high byte and the next read at the same pointer returns the low byte. Each read byte appears on the read data port one cycle after its read strobe.
- R2: A write is held back after its first (high) byte. The setpoint changes as a whole when the second (low) byte is written to the same pointer, so a read between the two bytes still returns the old value.
- R3: The four bottom bits of every written setpoint are stored as zero, whatever the low byte carried.
- R4: A write to any pointer other than 02h or 03h changes no setpoint. A read at such a pointer returns 00h.
- R5: One cycle after a sample strobe, the thermostat output is 1 if the masked signed sample is greater than or equal to the masked trip point.
- R6: Otherwise, the output drops to 0 only when the masked sample is below the masked release point. In every other case the output keeps its previous value, and it changes only after a sample strobe. It is 0 after reset.
- R7: Resolution code 00, 01, 10 or 11 makes the comparison ignore the bottom 3, 2, 1 or 0 bits of the 12-bit sample and of both setpoints.
- R8: The resolution field is read only at a sample strobe. Changing it between strobes does not alter the tick period.
- R9: The conversion tick is a one-cycle pulse repeating every BASE_TICKS×2^code cycles for the adopted resolution code. Code 11 is adopted at reset.
- R10: A sample strobe that carries a resolution code different from the adopted one restarts the period counter. The next tick then comes BASE_TICKS×2^code + 1 cycles after the cycle in which the strobe was driven.
- R11: All comparisons are two's complement. Below-zero setpoints such as FF80h (−0.5 °C) and C900h (−55 °C) order correctly against positive and negative samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_ptr | input | 8 | Register pointer (02h release point, 03h trip point) |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | 8 | Write byte |
| reg_rd | input | 1 | Byte read strobe |
| reg_rdata | output | 8 | Registered read byte |
| res_sel | input | 2 | Resolution code: 00=9, 01=10, 10=11, 11=12 bits |
| temp_valid | input | 1 | Sample strobe |
| temp_sample | input | 12 | Signed temperature sample, 1/16 °C per LSB |
| thermo_out | output | 1 | Registered thermostat output |
| conv_tick | output | 1 | Conversion-period tick pulse |

## Verification
Every result comes out of a single register stage. A read byte and the thermostat decision both appear exactly one clock after the strobe that causes them, so the bench drives on the falling edge and reads the result on the following falling edge, before any later stimulus. Tick timing is counted in whole falling edges from the edge that drove the strobe: the first tick after a restart is due one cycle later than the steady period, and each later gap equals the period exactly. Setpoint writes are confirmed only through later reads at the ports.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam int SAMPLE_W = 12;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int PTR_W    = 8;
  localparam int RES_W    = 2;
  localparam int FRAC_W   = WORD_W - SAMPLE_W;

  typedef enum logic [RES_W-1:0] {
    RES_9B  = 2'b00,
    RES_10B = 2'b01,
    RES_11B = 2'b10,
    RES_12B = 2'b11
  } res_code_e;

  localparam logic [PTR_W-1:0]  PTR_RELEASE  = 8'h02;
  localparam logic [PTR_W-1:0]  PTR_TRIP     = 8'h03;
  localparam logic [WORD_W-1:0] RELEASE_INIT = 16'h4B00;
  localparam logic [WORD_W-1:0] TRIP_INIT    = 16'h5000;
endpackage

// File: rtl/thermo_setpoint_regs.sv
module thermo_setpoint_regs
  import thermo_pkg::*;
#(
  parameter int P_PTR_W  = PTR_W,
  parameter int P_BYTE_W = BYTE_W,
  parameter int P_WORD_W = WORD_W,
  parameter int P_FRAC_W = FRAC_W,
  parameter logic [P_PTR_W-1:0]  P_REL_PTR  = PTR_RELEASE,
  parameter logic [P_PTR_W-1:0]  P_TRIP_PTR = PTR_TRIP,
  parameter logic [P_WORD_W-1:0] P_REL_INIT = RELEASE_INIT,
  parameter logic [P_WORD_W-1:0] P_TRIP_INIT = TRIP_INIT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [P_PTR_W-1:0]  ptr,
  input  logic                wr_en,
  input  logic [P_BYTE_W-1:0] wr_data,
  input  logic                rd_en,
  output logic [P_BYTE_W-1:0] rd_data,
  output logic [P_WORD_W-1:0] release_sp,
  output logic [P_WORD_W-1:0] trip_sp
);
  localparam int NREG = 2;
  localparam logic [P_WORD_W-1:0] FRAC_CLR = ~((P_WORD_W)'((1 << P_FRAC_W) - 1));
  localparam logic [NREG-1:0][P_WORD_W-1:0] INIT = {P_TRIP_INIT, P_REL_INIT};
  localparam logic [NREG-1:0][P_PTR_W-1:0]  PTRS = {P_TRIP_PTR, P_REL_PTR};

  logic [NREG-1:0][P_WORD_W-1:0] sp_q;
  logic [NREG-1:0] hit;
  logic            any_hit;
  logic            cur_idx;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_decode
    assign hit[gi] = (ptr == PTRS[gi]);
  end
  assign any_hit = |hit;
  assign cur_idx = hit[1];

  // write staging: high byte waits for its partner
  logic                wr_pend;
  logic                wr_idx;
  logic [P_BYTE_W-1:0] wr_hold;
  logic                commit;

  assign commit = wr_en && any_hit && wr_pend && (wr_idx == cur_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend <= 1'b0;
      wr_idx  <= 1'b0;
      wr_hold <= '0;
    end else if (wr_en) begin
      if (!any_hit) begin
        wr_pend <= 1'b0;
      end else if (commit) begin
        wr_pend <= 1'b0;
      end else begin
        wr_pend <= 1'b1;
        wr_idx  <= cur_idx;
        wr_hold <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= INIT;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (commit && (wr_idx == 1'(i)))
          sp_q[i] <= {wr_hold, wr_data} & FRAC_CLR;
      end
    end
  end

  // read sequencing: high byte, then low byte at the same pointer
  logic rd_pend;
  logic rd_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      rd_idx  <= 1'b0;
      rd_data <= '0;
    end else if (rd_en) begin
      if (!any_hit) begin
        rd_pend <= 1'b0;
        rd_data <= '0;
      end else if (rd_pend && (rd_idx == cur_idx)) begin
        rd_pend <= 1'b0;
        rd_data <= sp_q[cur_idx][P_BYTE_W-1:0];
      end else begin
        rd_pend <= 1'b1;
        rd_idx  <= cur_idx;
        rd_data <= sp_q[cur_idx][P_WORD_W-1 -: P_BYTE_W];
      end
    end
  end

  assign release_sp = sp_q[0];
  assign trip_sp    = sp_q[1];

  // R2: setpoints only move on a write strobe
  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(sp_q));
  // R4: reads at foreign pointers return zero
  p_foreign_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !any_hit) |=> (rd_data == '0));
  // R4: writes at foreign pointers touch nothing
  p_foreign_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !any_hit) |=> $stable(sp_q));
endmodule

// File: rtl/thermo_compare.sv
module thermo_compare
  import thermo_pkg::*;
#(
  parameter int P_SAMPLE_W = SAMPLE_W,
  parameter int P_WORD_W   = WORD_W,
  parameter int P_RES_W    = RES_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sample_valid,
  input  logic [P_SAMPLE_W-1:0] sample,
  input  logic [P_RES_W-1:0]    res_sel,
  input  logic [P_WORD_W-1:0]   trip_word,
  input  logic [P_WORD_W-1:0]   release_word,
  output logic                  thermo_q
);
  localparam int FW = P_WORD_W - P_SAMPLE_W;
  localparam logic [P_RES_W-1:0] RES_TOP = '1;

  logic [P_RES_W-1:0]    drop;
  logic [P_SAMPLE_W-1:0] keep;
  logic signed [P_SAMPLE_W-1:0] s_m, trip_m, rel_m;
  logic at_or_above, below_release;

  assign drop = RES_TOP - res_sel;
  assign keep = {P_SAMPLE_W{1'b1}} << drop;

  assign s_m    = $signed(sample & keep);
  assign trip_m = $signed(trip_word[P_WORD_W-1:FW] & keep);
  assign rel_m  = $signed(release_word[P_WORD_W-1:FW] & keep);

  assign at_or_above   = (s_m >= trip_m);
  assign below_release = (s_m < rel_m);

  always_ff @(posedge clk) begin
    if (rst)
      thermo_q <= 1'b0;
    else if (sample_valid) begin
      if (at_or_above)
        thermo_q <= 1'b1;
      else if (below_release)
        thermo_q <= 1'b0;
    end
  end

  // R3: stored setpoints never carry fraction bits below 1/16 degree
  p_frac_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (trip_word[FW-1:0] == '0) && (release_word[FW-1:0] == '0));
  // R6: output moves only after a sample strobe
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(thermo_q));
  // R5: an unmasked sample at or above the unmasked trip also trips after masking
  p_trip_r5: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && ($signed(sample) >= $signed(trip_word[P_WORD_W-1:FW])))
      |=> thermo_q);
endmodule

// File: rtl/thermo_conv_timer.sv
module thermo_conv_timer
  import thermo_pkg::*;
#(
  parameter int unsigned P_BASE_TICKS = 7_500_000,
  parameter int P_RES_W = RES_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_valid,
  input  logic [P_RES_W-1:0] res_sel,
  output logic               tick
);
  localparam int NCODE = 1 << P_RES_W;
  localparam longint unsigned MAXLIM = longint'(P_BASE_TICKS) << (NCODE - 1);
  localparam int CNT_W = $clog2(MAXLIM + 1);

  logic [CNT_W-1:0]   lim [NCODE];
  logic [CNT_W-1:0]   cnt;
  logic [P_RES_W-1:0] res_act;
  logic               restart;

  for (genvar gi = 0; gi < NCODE; gi++) begin : g_limit
    localparam longint unsigned L = longint'(P_BASE_TICKS) << gi;
    assign lim[gi] = CNT_W'(L);
  end

  assign restart = sample_valid && (res_sel != res_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_act <= '1;
      cnt     <= '0;
      tick    <= 1'b0;
    end else if (restart) begin
      res_act <= res_sel;
      cnt     <= '0;
      tick    <= 1'b0;
    end else if (cnt == lim[res_act] - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R9: counter stays inside the adopted period
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (rst)
    cnt < lim[res_act]);
  // R9: tick is a lone pulse
  p_tick_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R10: a strobe with a new code restarts the count
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && (res_sel != res_act)) |=> ((cnt == '0) && !tick));
  // R8: adopted code only moves at a strobe
  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(res_act));
endmodule

// File: rtl/thermo_setpoint_unit.sv
module thermo_setpoint_unit
  import thermo_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 7_500_000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PTR_W-1:0]    reg_ptr,
  input  logic                reg_wr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  input  logic                reg_rd,
  output logic [BYTE_W-1:0]   reg_rdata,
  input  logic [RES_W-1:0]    res_sel,
  input  logic                temp_valid,
  input  logic [SAMPLE_W-1:0] temp_sample,
  output logic                thermo_out,
  output logic                conv_tick
);
  logic [WORD_W-1:0] release_sp;
  logic [WORD_W-1:0] trip_sp;

  thermo_setpoint_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .ptr        (reg_ptr),
    .wr_en      (reg_wr),
    .wr_data    (reg_wdata),
    .rd_en      (reg_rd),
    .rd_data    (reg_rdata),
    .release_sp (release_sp),
    .trip_sp    (trip_sp)
  );

  thermo_compare u_cmp (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (temp_valid),
    .sample       (temp_sample),
    .res_sel      (res_sel),
    .trip_word    (trip_sp),
    .release_word (release_sp),
    .thermo_q     (thermo_out)
  );

  thermo_conv_timer #(.P_BASE_TICKS(BASE_TICKS)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (temp_valid),
    .res_sel      (res_sel),
    .tick         (conv_tick)
  );
endmodule

// File: tb/thermo_setpoint_unit_bench.sv
module thermo_setpoint_unit_bench;
  localparam int unsigned BASE = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_ptr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic [1:0]  res_sel = 2'b11;
  logic        temp_valid = 1'b0;
  logic [11:0] temp_sample = '0;
  logic        thermo_out;
  logic        conv_tick;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  thermo_setpoint_unit #(.BASE_TICKS(BASE)) u_thermo_setpoint_unit (
    .clk(clk), .rst(rst), .reg_ptr(reg_ptr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .res_sel(res_sel), .temp_valid(temp_valid), .temp_sample(temp_sample),
    .thermo_out(thermo_out), .conv_tick(conv_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    reg_ptr = p; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_word(input logic [7:0] p, input logic [15:0] w);
    wr_byte(p, w[15:8]);
    wr_byte(p, w[7:0]);
  endtask

  task automatic rd_word(input logic [7:0] p, output logic [15:0] w);
    @(negedge clk);
    reg_ptr = p; reg_rd = 1'b1;
    @(negedge clk);
    w[15:8] = reg_rdata;
    @(negedge clk);
    w[7:0] = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic strobe(input logic [11:0] s, input logic [1:0] r,
                        input int exp, input string req);
    @(negedge clk);
    temp_sample = s; res_sel = r; temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
    check(req, int'(thermo_out), exp);
  endtask

  task automatic t_reset();
    logic [15:0] w;
    check("R6 reset output", int'(thermo_out), 0);
    check("R9 reset tick", int'(conv_tick), 0);
    rd_word(8'h03, w); check("R1 trip reset", int'(w), 'h5000);
    rd_word(8'h02, w); check("R1 release reset", int'(w), 'h4B00);
  endtask

  task automatic t_writes();
    logic [15:0] w;
    wr_byte(8'h02, 8'h12);
    rd_word(8'h02, w); check("R2 half write invisible", int'(w), 'h4B00);
    wr_byte(8'h02, 8'h34);
    rd_word(8'h02, w); check("R2 commit + R3 frac clear", int'(w), 'h1230);
    wr_word(8'h03, 16'h505F);
    rd_word(8'h03, w); check("R3 frac clear", int'(w), 'h5050);
    wr_word(8'h02, 16'h4B00);
    wr_word(8'h03, 16'h5000);
  endtask

  task automatic t_foreign();
    logic [15:0] w;
    wr_word(8'h01, 16'hAAAA);
    wr_word(8'h04, 16'h5555);
    rd_word(8'h03, w); check("R4 trip untouched", int'(w), 'h5000);
    rd_word(8'h02, w); check("R4 release untouched", int'(w), 'h4B00);
    rd_word(8'h01, w); check("R4 foreign read zero", int'(w), 0);
  endtask

  task automatic t_hysteresis();
    strobe(12'h4C0, 2'b11, 0, "R6 hold low between limits");
    strobe(12'h500, 2'b11, 1, "R5 trip at equal");
    strobe(12'h4B0, 2'b11, 1, "R6 hold high at release");
    strobe(12'h4AF, 2'b11, 0, "R6 clear below release");
  endtask

  task automatic t_resolution();
    wr_word(8'h03, 16'h5050);
    strobe(12'h500, 2'b11, 0, "R7 12-bit no trip");
    strobe(12'h500, 2'b00, 1, "R7 9-bit ignores 3 bits");
    strobe(12'h4AF, 2'b00, 0, "R7 9-bit clear");
    strobe(12'h503, 2'b01, 0, "R7 10-bit below");
    strobe(12'h504, 2'b01, 1, "R7 10-bit equal trips");
    strobe(12'h4AF, 2'b11, 0, "R6 clear again");
  endtask

  task automatic t_signed();
    wr_word(8'h03, 16'hFF80);
    wr_word(8'h02, 16'hC900);
    strobe(12'h000, 2'b11, 1, "R11 zero above -0.5");
    strobe(12'hC8F, 2'b11, 0, "R11 below -55");
    strobe(12'hFF0, 2'b11, 0, "R11 hold at -1");
  endtask

  task automatic count_to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!conv_tick && n < 2000);
  endtask

  task automatic t_timer();
    int n;
    @(negedge clk);
    res_sel = 2'b00; temp_valid = 1'b1;
    count_to_tick(n);
    temp_valid = 1'b0;
    check("R10 restart to first tick", n, BASE + 1);
    count_to_tick(n); check("R9 period code 00", n, BASE);
    res_sel = 2'b10;
    count_to_tick(n); check("R8 no strobe keeps period", n, BASE);
    @(negedge clk);
    temp_valid = 1'b1;
    count_to_tick(n);
    temp_valid = 1'b0;
    check("R10 restart code 10", n, BASE * 4 + 1);
    count_to_tick(n); check("R9 period code 10", n, BASE * 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_writes();
    t_foreign();
    t_hysteresis();
    t_resolution();
    t_signed();
    t_timer();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule